// File: doc/BRIEF.md
# Peripheral Chip Select Decoder

This block turns CPU bus addresses into seven active-low peripheral chip selects. The peripheral window is seven back-to-back 256-byte regions that start at a base address aligned to 2 KB. Configuration places the window in memory space or in I/O space. A select drops in the same cycle that the address strobe presents the address. It then stays asserted until the bus interface signals the end of the cycle. The block also supplies the wait-state count for the active region. When a DRAM bank decode claims the same address, the peripheral select wins: the block raises a DRAM inhibit and applies the larger of the two wait counts.

A mode bit can turn the two highest select pins into latched address outputs carrying address bits 1 and 2. During a bus hold the select pins are released to a weak pull-up, while latched address pins keep their last value. A small state machine controls the select timing. Its states are ST_UNCFG (base not yet written), ST_IDLE, ST_ACTIVE and ST_HOLD. Its transitions are:

- ST_UNCFG to ST_IDLE on a base write.
- ST_IDLE to ST_ACTIVE on a strobed hit.
- ST_IDLE to ST_HOLD when hold is raised.
- ST_ACTIVE to ST_IDLE on end of cycle.
- ST_HOLD to ST_IDLE when hold is dropped.

Top module: `pcs_decoder`

## Requirements
- R1: With base B = cfg_base×2048, an access to an address in [B+256k, B+256k+255] for k in 0..6 drives pcs_n[k] low, and every other select pin stays high.
- R2: A select asserts only when bus_is_mem equals cfg_mem_space (1 = memory space, 0 = I/O space).
- R3: A select goes low in the cycle where bus_ale is high, holds through the cycle in which bus_cyc_end is high (address changes meanwhile are ignored), and is high in the following cycle.
- R4: An address below B, or at or above B+1792, asserts no select and gives wait_cnt 0.
- R5: After reset no select asserts until cfg_base_we has been pulsed once.
- R6: While a select is low and dram_hit is high, dram_inhibit is 1 and wait_cnt is the larger of the region's wait count and dram_wait; otherwise dram_inhibit is 0.
- R7: wait_cnt is cfg_wait_std (2 bits, zero-extended) for regions 0–4 and cfg_wait_ext (4 bits) for regions 5–6. It is 0 when no select is active.
- R8: While bus_hold is high, select pins have pcs_oe low and pcs_n high, and a strobe is ignored. In the first cycle after hold drops the outputs are driven again, but a strobe is still ignored.
- R9: While rst_n is low, every pcs_n bit is high and every pcs_oe bit is low.
- R10: With cfg_sel_mode = 0, pin 5 carries address bit 1 and pin 6 carries address bit 2, as latched on the last clock edge where bus_ale was high without hold. Regions 5 and 6 then assert no select.
- R11: With cfg_sel_mode = 0, the latched-address pins stay driven (pcs_oe high) and keep their value during a bus hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 20 | Multiplexed bus address |
| bus_ale | input | 1 | Address strobe, high for the address cycle |
| bus_is_mem | input | 1 | 1 = memory access, 0 = I/O access |
| bus_cyc_end | input | 1 | High in the last cycle of the bus cycle |
| bus_hold | input | 1 | Bus hold granted to another master |
| cfg_base_we | input | 1 | Base register write strobe |
| cfg_base | input | 9 | Base address bits 19:11 |
| cfg_mem_space | input | 1 | Window space select (1 = memory) |
| cfg_sel_mode | input | 1 | 1 = pins 5/6 are selects, 0 = latched address |
| cfg_wait_std | input | 2 | Wait count for regions 0–4 |
| cfg_wait_ext | input | 4 | Extended wait count for regions 5–6 |
| dram_hit | input | 1 | DRAM bank decode hit for current access |
| dram_wait | input | 4 | Wait count of the hit DRAM bank |
| pcs_n | output | 7 | Active-low selects (5/6 may carry latched address) |
| pcs_oe | output | 7 | Output enables of the select pins |
| dram_inhibit | output | 1 | Suppresses the overlapping DRAM access |
| wait_cnt | output | 4 | Wait states for the current access |

## Verification
The bench builds the block with its default parameters: a 20-bit address, seven 256-byte regions, a 9-bit base above bit 10, a 2-bit standard wait field and a 4-bit extended one. With these values, regions 5 and 6 can carry an extended wait of 9, which exceeds anything the standard field can encode. The DRAM maximum can therefore be exercised from both sides. A base of 0x09000 puts the window's lower edge and its eighth-region edge at clean addresses for the out-of-range cases.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [1:0] {
        ST_UNCFG  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_HOLD   = 2'd3
    } pcs_state_e;
endpackage

// File: rtl/pcs_region_dec.sv
module pcs_region_dec #(
    parameter int ADDR_W   = 20,
    parameter int RGN_SH   = 8,
    parameter int BASE_LSB = 11,
    parameter int N_SEL    = 7
) (
    input  logic [ADDR_W-RGN_SH-1:0]   addr_hi,
    input  logic [ADDR_W-BASE_LSB-1:0] base,
    output logic [N_SEL-1:0]           onehot
);
    localparam int IDX_W = ADDR_W - RGN_SH;
    localparam int PAD   = BASE_LSB - RGN_SH;

    logic [IDX_W:0] diff;
    logic           in_range;

    always_comb begin
        diff     = {1'b0, addr_hi} - {1'b0, base, {PAD{1'b0}}};
        in_range = !diff[IDX_W] && (diff[IDX_W-1:0] < IDX_W'(N_SEL));
    end

    for (genvar k = 0; k < N_SEL; k++) begin : g_rgn
        assign onehot[k] = in_range && (diff[IDX_W-1:0] == IDX_W'(k));
    end
endmodule

// File: rtl/pcs_wait_sel.sv
module pcs_wait_sel #(
    parameter int N_SEL = 7,
    parameter int WS_W  = 2,
    parameter int WE_W  = 4
) (
    input  logic [N_SEL-1:0] sel,
    input  logic [WS_W-1:0]  wait_std,
    input  logic [WE_W-1:0]  wait_ext,
    input  logic             dram_hit,
    input  logic [WE_W-1:0]  dram_wait,
    output logic [WE_W-1:0]  wait_cnt,
    output logic             inhibit
);
    localparam int N_STD = N_SEL - 2;

    logic [WE_W-1:0] per_sel [N_SEL];
    logic [WE_W-1:0] rgn_wait;

    for (genvar k = 0; k < N_SEL; k++) begin : g_w
        if (k < N_STD) begin : g_std
            assign per_sel[k] = sel[k] ? WE_W'(wait_std) : '0;
        end else begin : g_ext
            assign per_sel[k] = sel[k] ? wait_ext : '0;
        end
    end

    always_comb begin
        rgn_wait = '0;
        for (int k = 0; k < N_SEL; k++) begin
            rgn_wait = rgn_wait | per_sel[k];
        end
        inhibit  = dram_hit && (|sel);
        wait_cnt = (inhibit && (dram_wait > rgn_wait)) ? dram_wait : rgn_wait;
    end
endmodule

// File: rtl/pcs_ctrl_fsm.sv
module pcs_ctrl_fsm
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic base_we,
    input  logic start,
    input  logic hold,
    input  logic cyc_end,
    output logic in_idle,
    output logic in_active
);
    pcs_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNCFG;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_UNCFG:  if (base_we) state_nx = ST_IDLE;
            ST_IDLE:   if (hold) state_nx = ST_HOLD;
                       else if (start) state_nx = ST_ACTIVE;
            ST_ACTIVE: if (cyc_end) state_nx = ST_IDLE;
            ST_HOLD:   if (!hold) state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_idle   = 1'b0;
        in_active = 1'b0;
        unique case (state)
            ST_UNCFG:  ;
            ST_IDLE:   in_idle   = 1'b1;
            ST_ACTIVE: in_active = 1'b1;
            ST_HOLD:   ;
        endcase
    end
endmodule

// File: rtl/pcs_decoder.sv
module pcs_decoder #(
    parameter int ADDR_W   = 20,
    parameter int RGN_SH   = 8,
    parameter int BASE_LSB = 11,
    parameter int N_SEL    = 7,
    parameter int WS_W     = 2,
    parameter int WE_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_ale,
    input  logic                       bus_is_mem,
    input  logic                       bus_cyc_end,
    input  logic                       bus_hold,
    input  logic                       cfg_base_we,
    input  logic [ADDR_W-BASE_LSB-1:0] cfg_base,
    input  logic                       cfg_mem_space,
    input  logic                       cfg_sel_mode,
    input  logic [WS_W-1:0]            cfg_wait_std,
    input  logic [WE_W-1:0]            cfg_wait_ext,
    input  logic                       dram_hit,
    input  logic [WE_W-1:0]            dram_wait,
    output logic [N_SEL-1:0]           pcs_n,
    output logic [N_SEL-1:0]           pcs_oe,
    output logic                       dram_inhibit,
    output logic [WE_W-1:0]            wait_cnt
);
    localparam int N_STD  = N_SEL - 2;
    localparam int BASE_W = ADDR_W - BASE_LSB;

    logic [BASE_W-1:0] base_q;
    logic [N_SEL-1:0]  dec_raw, dec_ok, sel_q, act_vec;
    logic [1:0]        la_q;
    logic              in_idle, in_active, start_now, space_ok;
    logic [N_SEL-1:0]  mode_mask;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{bus_addr[RGN_SH-1:3], bus_addr[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else if (cfg_base_we) base_q <= cfg_base;
    end

    pcs_region_dec #(
        .ADDR_W(ADDR_W), .RGN_SH(RGN_SH), .BASE_LSB(BASE_LSB), .N_SEL(N_SEL)
    ) u_dec (
        .addr_hi (bus_addr[ADDR_W-1:RGN_SH]),
        .base    (base_q),
        .onehot  (dec_raw)
    );

    always_comb begin
        space_ok  = (bus_is_mem == cfg_mem_space);
        mode_mask = {{2{cfg_sel_mode}}, {N_STD{1'b1}}};
        dec_ok    = space_ok ? (dec_raw & mode_mask) : '0;
        start_now = in_idle && bus_ale && !bus_hold && (|dec_ok);
    end

    pcs_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_we   (cfg_base_we),
        .start     (start_now),
        .hold      (bus_hold),
        .cyc_end   (bus_cyc_end),
        .in_idle   (in_idle),
        .in_active (in_active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            la_q  <= '0;
        end else begin
            if (start_now) sel_q <= dec_ok;
            if (bus_ale && !bus_hold) la_q <= bus_addr[2:1];
        end
    end

    always_comb begin
        if (in_active)      act_vec = sel_q;
        else if (start_now) act_vec = dec_ok;
        else                act_vec = '0;
    end

    pcs_wait_sel #(
        .N_SEL(N_SEL), .WS_W(WS_W), .WE_W(WE_W)
    ) u_wait (
        .sel       (act_vec),
        .wait_std  (cfg_wait_std),
        .wait_ext  (cfg_wait_ext),
        .dram_hit  (dram_hit && !bus_hold),
        .dram_wait (dram_wait),
        .wait_cnt  (wait_cnt),
        .inhibit   (dram_inhibit)
    );

    for (genvar k = 0; k < N_SEL; k++) begin : g_pin
        if (k < N_STD) begin : g_sel
            assign pcs_n[k]  = !rst_n || bus_hold || !act_vec[k];
            assign pcs_oe[k] = rst_n && !bus_hold;
        end else begin : g_dual
            assign pcs_n[k]  = !rst_n ? 1'b1 :
                               cfg_sel_mode ? (bus_hold || !act_vec[k]) :
                               la_q[k-N_STD];
            assign pcs_oe[k] = rst_n && (!bus_hold || !cfg_sel_mode);
        end
    end
endmodule

// File: rtl/pcs_decoder_chk.sv
module pcs_decoder_chk #(
    parameter int N_SEL  = 7,
    parameter int WAIT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_hold,
    input logic              cfg_sel_mode,
    input logic              dram_hit,
    input logic [WAIT_W-1:0] dram_wait,
    input logic [N_SEL-1:0]  pcs_n,
    input logic [N_SEL-1:0]  pcs_oe,
    input logic              dram_inhibit,
    input logic [WAIT_W-1:0] wait_cnt
);
    always @(posedge clk) begin
        if (!rst_n) begin
            // R9
            reset_release_chk: assert (pcs_oe == '0 && pcs_n == '1);
        end
    end

    // R1
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pcs_n[N_SEL-3:0]) && (!cfg_sel_mode || $onehot0(~pcs_n)));

    // R8
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hold && cfg_sel_mode) |-> (pcs_oe == '0 && pcs_n == '1));

    // R11
    hold_addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hold && !cfg_sel_mode) |-> (pcs_oe == {2'b11, {(N_SEL-2){1'b0}}}));

    // R11
    hold_addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hold && $past(bus_hold) && !cfg_sel_mode && !$past(cfg_sel_mode))
        |-> (pcs_n[N_SEL-1:N_SEL-2] == $past(pcs_n[N_SEL-1:N_SEL-2])));

    // R6
    inhibit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_inhibit |-> (dram_hit && !bus_hold && pcs_n != '1));

    // R6
    inhibit_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_inhibit |-> (wait_cnt >= dram_wait));
endmodule

bind pcs_decoder pcs_decoder_chk #(.N_SEL(N_SEL), .WAIT_W(WE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_hold     (bus_hold),
    .cfg_sel_mode (cfg_sel_mode),
    .dram_hit     (dram_hit),
    .dram_wait    (dram_wait),
    .pcs_n        (pcs_n),
    .pcs_oe       (pcs_oe),
    .dram_inhibit (dram_inhibit),
    .wait_cnt     (wait_cnt)
);

// File: tb/sim_pcs_decoder.sv
`timescale 1ns/1ps
module sim_pcs_decoder;
    localparam int CLK_HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_ale = 1'b0, bus_is_mem = 1'b0, bus_cyc_end = 1'b0, bus_hold = 1'b0;
    logic        cfg_base_we = 1'b0;
    logic [8:0]  cfg_base = '0;
    logic        cfg_mem_space = 1'b0, cfg_sel_mode = 1'b1;
    logic [1:0]  cfg_wait_std = 2'd2;
    logic [3:0]  cfg_wait_ext = 4'd9;
    logic        dram_hit = 1'b0;
    logic [3:0]  dram_wait = '0;
    logic [6:0]  pcs_n, pcs_oe;
    logic        dram_inhibit;
    logic [3:0]  wait_cnt;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic [18:0] exp_q [$];
    string       tag_q [$];

    always #CLK_HALF clk = ~clk;

    pcs_decoder u0 (.*);

    task automatic push(input logic [6:0] p, input logic [6:0] o, input logic inh,
                        input logic [3:0] w, input string tag);
        exp_q.push_back({p, o, inh, w});
        tag_q.push_back(tag);
    endtask

    task automatic nxt();
        @(negedge clk);
        bus_ale = 1'b0;
        bus_cyc_end = 1'b0;
        cfg_base_we = 1'b0;
    endtask

    // monitor: compare away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (exp_q.size() > 0) begin
                logic [18:0] e;
                logic [18:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {pcs_n, pcs_oe, dram_inhibit, wait_cnt};
                n_vec++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: pcs_n=%h oe=%h inh=%b wait=%0d, expected pcs_n=%h oe=%h inh=%b wait=%0d",
                             t, a[18:12], a[11:5], a[4], a[3:0], e[18:12], e[11:5], e[4], e[3:0]);
                end
            end
        end
    end

    initial begin
        #(CLK_HALF * 2 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        nxt(); push(7'h7F, 7'h00, 0, 0, "R9 reset state");
        nxt(); rst_n = 1; bus_ale = 1; bus_addr = 20'h00000;
        push(7'h7F, 7'h7F, 0, 0, "R5 no select before base write");
        nxt(); cfg_base_we = 1; cfg_base = 9'h012;
        push(7'h7F, 7'h7F, 0, 0, "R5 base write cycle");
        // R1 R3 region 0 access
        nxt(); bus_ale = 1; bus_addr = 20'h09000;
        push(7'h7E, 7'h7F, 0, 2, "R3 select in strobe cycle");
        nxt(); bus_addr = 20'h00000;
        push(7'h7E, 7'h7F, 0, 2, "R3 held while address changes");
        nxt(); bus_cyc_end = 1;
        push(7'h7E, 7'h7F, 0, 2, "R3 held in end cycle");
        nxt(); push(7'h7F, 7'h7F, 0, 0, "R3 released after end");
        // R7 region 6 extended wait
        nxt(); bus_ale = 1; bus_addr = 20'h09650;
        push(7'h3F, 7'h7F, 0, 9, "R1 R7 region 6 extended wait");
        nxt(); bus_cyc_end = 1; push(7'h3F, 7'h7F, 0, 9, "R7 region 6 end");
        nxt(); bus_ale = 1; bus_addr = 20'h09400;
        push(7'h6F, 7'h7F, 0, 2, "R1 R7 region 4 standard wait");
        nxt(); bus_cyc_end = 1; push(7'h6F, 7'h7F, 0, 2, "R7 region 4 end");
        // R4 out of range
        nxt(); bus_ale = 1; bus_addr = 20'h09700;
        push(7'h7F, 7'h7F, 0, 0, "R4 index 7");
        nxt(); bus_ale = 1; bus_addr = 20'h08F00;
        push(7'h7F, 7'h7F, 0, 0, "R4 below base");
        // R2 space qualifier
        nxt(); bus_ale = 1; bus_addr = 20'h09000; bus_is_mem = 1;
        push(7'h7F, 7'h7F, 0, 0, "R2 memory access to I/O window");
        nxt(); bus_ale = 1; cfg_mem_space = 1;
        push(7'h7E, 7'h7F, 0, 2, "R2 memory window hit");
        nxt(); bus_cyc_end = 1; push(7'h7E, 7'h7F, 0, 2, "R2 end");
        nxt(); bus_is_mem = 0; cfg_mem_space = 0; push(7'h7F, 7'h7F, 0, 0, "R2 idle");
        // R6 DRAM overlap
        nxt(); bus_ale = 1; bus_addr = 20'h09100; dram_hit = 1; dram_wait = 4'd5;
        push(7'h7D, 7'h7F, 1, 5, "R6 dram wait larger");
        nxt(); bus_cyc_end = 1; push(7'h7D, 7'h7F, 1, 5, "R6 dram end");
        nxt(); bus_ale = 1; bus_addr = 20'h09500; dram_wait = 4'd1;
        push(7'h5F, 7'h7F, 1, 9, "R6 region wait larger");
        nxt(); bus_cyc_end = 1; push(7'h5F, 7'h7F, 1, 9, "R6 end");
        nxt(); bus_ale = 1; bus_addr = 20'h00000;
        push(7'h7F, 7'h7F, 0, 0, "R6 dram only no inhibit");
        nxt(); dram_hit = 0; dram_wait = 0;
        // R8 hold with selects
        nxt(); bus_hold = 1; push(7'h7F, 7'h00, 0, 0, "R8 hold floats selects");
        nxt(); bus_ale = 1; bus_addr = 20'h09000;
        push(7'h7F, 7'h00, 0, 0, "R8 strobe ignored in hold");
        nxt(); bus_hold = 0; bus_ale = 1;
        push(7'h7F, 7'h7F, 0, 0, "R8 strobe ignored leaving hold");
        nxt(); push(7'h7F, 7'h7F, 0, 0, "R8 idle after hold");
        // R10 latched address mode
        nxt(); cfg_sel_mode = 0; push(7'h1F, 7'h7F, 0, 0, "R10 pins show latched 00");
        nxt(); bus_ale = 1; bus_addr = 20'h09006;
        push(7'h1E, 7'h7F, 0, 2, "R10 region 0 still selects");
        nxt(); bus_cyc_end = 1; push(7'h7E, 7'h7F, 0, 2, "R10 latched 11");
        nxt(); push(7'h7F, 7'h7F, 0, 0, "R10 idle");
        nxt(); bus_ale = 1; bus_addr = 20'h09500;
        push(7'h7F, 7'h7F, 0, 0, "R10 region 5 no select");
        nxt(); push(7'h1F, 7'h7F, 0, 0, "R10 latched 00 from region 5 strobe");
        nxt(); bus_ale = 1; bus_addr = 20'h09002;
        push(7'h1E, 7'h7F, 0, 2, "R10 strobe a1");
        nxt(); bus_cyc_end = 1; push(7'h3E, 7'h7F, 0, 2, "R10 a1=1 a2=0");
        // R11 hold in latched mode
        nxt(); bus_hold = 1; bus_ale = 1; bus_addr = 20'h09004;
        push(7'h3F, 7'h60, 0, 0, "R11 hold keeps address pins");
        nxt(); push(7'h3F, 7'h60, 0, 0, "R11 hold second cycle");
        nxt(); bus_hold = 0; push(7'h3F, 7'h7F, 0, 0, "R11 after hold");
        nxt(); nxt();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule